// File: doc/BRIEF.md
# Repeat-Mode ADC Sequencing Controller

This block is the digital side of a successive-approximation converter that samples one selected channel over and over. Software programs a two-bit mode field and a channel number through a small register bus, then sets a start bit. The controller sends a one-cycle start pulse to an external conversion engine, waits for the engine's done strobe, stores the returned code, raises an end-of-conversion flag, pulses an interrupt, and at once starts the next conversion on the same channel. This continues until software writes the stop mode.

The result is split over two byte registers: a low byte carrying the two least significant code bits at its top, and a high byte carrying the eight upper bits. Reading the low byte arms a lock that holds the stored pair steady. A conversion that completes while the lock is armed is discarded with no interrupt, so the two halves read by software always belong to the same sample. Reading the high byte releases the lock and clears the end-of-conversion flag.

Top module: `adc_repeat_seq`

## Requirements
- R1: After reset the control register reads 0 (mode 00, start 0, channel 0), the status register reads 0, and neither `irq` nor `conv_start` is high.
- R2: A control write launches a conversion only when the mode field written is 11 and the start bit is 1; it then produces exactly one single-cycle `conv_start` pulse, in the second cycle after the write. Writing start with mode 01 launches nothing.
- R3: The start bit (control bit 2) reads back 0 once the conversion has begun, while mode (bits 1:0) and channel (bits 7:3) read back as written; `conv_chan` carries the written channel.
- R4: When a done strobe arrives with the lock released, the code is stored, status bit 0 (end of conversion) becomes 1, and `irq` is high for exactly one cycle, the cycle after the strobe.
- R5: After every done strobe accepted while running, `conv_start` is high in the very next cycle, on the same channel.
- R6: Reading the high result register (address 3) clears the end-of-conversion flag unless a result is stored in that same cycle.
- R7: Reading the low result register (address 2) arms a lock; a conversion completing while it is armed (including in the same cycle as the low read) leaves both result registers unchanged and raises no `irq`.
- R8: Reading the high result register releases the lock, and the next completion is stored and signalled normally.
- R9: Writing mode 00 stops the sequence at once: from the next cycle the busy flag is 0, no further `conv_start` or `irq` occurs, and the result registers keep the last stored value. It also releases the lock.
- R10: Status bit 1 (busy) rises when a conversion is launched and stays 1 across completions until mode 00 is written; `conv_start` is never high while busy is 0.
- R11: Address map: 0 control, 1 status (bit 0 end of conversion, bit 1 busy, rest 0), 2 low result with code bits 1:0 in bits 7:6 and bits 5:0 zero, 3 high result with code bits 9:2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads have side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| conv_start | output | 1 | One-cycle start pulse to the conversion engine |
| conv_chan | output | CH_W | Channel to convert |
| conv_done | input | 1 | Engine completion strobe |
| conv_code | input | RES_W | Code returned with the strobe |
| irq | output | 1 | One-cycle conversion-complete interrupt |

## Verification
The hardest state to reach from the ports is a completion arriving while the result pair is half read, because the engine runs free and the window only exists between two bus reads. The bench models the engine as a fixed-latency counter whose codes are an arithmetic function of channel and sequence number, reads the low byte right after an interrupt, then stalls until its own engine model reports the next done strobe before reading the high byte. It then checks that the interrupt count did not move, that the high byte still matches the earlier sample, and that the following completion comes through again. A forced stop is placed in the middle of a conversion by waiting a set number of cycles after a relaunch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam logic [1:0] ADDR_HI   = 2'd3;

  localparam logic [1:0] MODE_OFF    = 2'b00;
  localparam logic [1:0] MODE_REPEAT = 2'b11;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_LAUNCH = 2'd1,
    SQ_WAIT   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic [1:0]      wr_mode,
  input  logic            wr_start,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            busy,
  input  logic            launch,
  output logic [1:0]      mode,
  output logic            start,
  output logic [CH_W-1:0] chan,
  output logic            stop_req
);

  logic [1:0]      mode_q,  mode_n;
  logic            start_q, start_n;
  logic [CH_W-1:0] chan_q,  chan_n;
  logic            chan_en;

  // a control write carrying the off mode is the forced stop
  assign stop_req = wr_ctrl && (wr_mode == MODE_OFF);
  // channel and start are frozen while a sequence runs
  assign chan_en  = wr_ctrl && !busy;

  always_comb begin
    mode_n  = mode_q;
    start_n = start_q;
    chan_n  = chan_q;
    if (wr_ctrl) mode_n = wr_mode;
    if (chan_en) begin
      chan_n  = wr_chan;
      start_n = wr_start;
    end
    if (launch)   start_n = 1'b0;
    if (stop_req) start_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      mode_q  <= mode_n;
      start_q <= start_n;
      chan_q  <= chan_n;
    end
  end

  assign mode  = mode_q;
  assign start = start_q;
  assign chan  = chan_q;

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       start,
  input  logic       stop_req,
  input  logic       conv_done,
  output logic       launch,
  output logic       done_ok,
  output logic       conv_start,
  output logic       busy
);

  seq_state_e state_q, state_n;
  logic       busy_q,  busy_n;

  always_comb begin
    state_n = state_q;
    busy_n  = busy_q;
    launch  = 1'b0;
    done_ok = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start && (mode == MODE_REPEAT) && !stop_req) begin
          state_n = SQ_LAUNCH;
          busy_n  = 1'b1;
          launch  = 1'b1;
        end
      end
      SQ_LAUNCH: begin
        if (stop_req) begin
          state_n = SQ_IDLE;
          busy_n  = 1'b0;
        end else begin
          state_n = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (stop_req) begin
          state_n = SQ_IDLE;
          busy_n  = 1'b0;
        end else if (conv_done) begin
          done_ok = 1'b1;
          state_n = SQ_LAUNCH;
        end
      end
      default: begin
        state_n = SQ_IDLE;
        busy_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= busy_n;
    end
  end

  assign conv_start = (state_q == SQ_LAUNCH);
  assign busy       = busy_q;

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_ok,
  input  logic [RES_W-1:0] code,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic             stop_req,
  output logic [RES_W-1:0] result,
  output logic             eoc,
  output logic             lock,
  output logic             irq
);

  logic [RES_W-1:0] res_q;
  logic             eoc_q,  eoc_n;
  logic             lock_q, lock_n;
  logic             irq_q;
  logic             take;

  // a low-byte read in the same cycle already counts as half read
  assign take = done_ok && !(lock_q || rd_lo);

  always_comb begin
    lock_n = lock_q;
    if (rd_hi)    lock_n = 1'b0;
    if (rd_lo)    lock_n = 1'b1;
    if (stop_req) lock_n = 1'b0;
    eoc_n = eoc_q;
    if (rd_hi) eoc_n = 1'b0;
    if (take)  eoc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q  <= 1'b0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      eoc_q  <= eoc_n;
      lock_q <= lock_n;
      irq_q  <= take;
    end
  end

  // data storage needs no reset: contents before the first result are undefined
  always_ff @(posedge clk) begin
    if (take) res_q <= code;
  end

  assign result = res_q;
  assign eoc    = eoc_q;
  assign lock   = lock_q;
  assign irq    = irq_q;

endmodule

// File: rtl/adc_repeat_seq.sv
module adc_repeat_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_code,
  output logic             irq
);

  localparam int LO_BITS = RES_W - 8;
  localparam int CTRL_W  = 3 + CH_W;

  logic            rst_sync_n;
  logic            wr_ctrl, rd_lo, rd_hi;
  logic [1:0]      ctl_mode;
  logic            ctl_start;
  logic [CH_W-1:0] ctl_chan;
  logic            ctl_stop;
  logic            seq_launch, seq_done_ok, seq_busy;
  logic [RES_W-1:0] res_value;
  logic            res_eoc, res_lock;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_lo   = bus_rd && (bus_addr == ADDR_LO);
  assign rd_hi   = bus_rd && (bus_addr == ADDR_HI);

  adc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_ctrl_reg #(.CH_W(CH_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_ctrl  (wr_ctrl),
    .wr_mode  (bus_wdata[1:0]),
    .wr_start (bus_wdata[2]),
    .wr_chan  (bus_wdata[2+CH_W:3]),
    .busy     (seq_busy),
    .launch   (seq_launch),
    .mode     (ctl_mode),
    .start    (ctl_start),
    .chan     (ctl_chan),
    .stop_req (ctl_stop)
  );

  adc_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode       (ctl_mode),
    .start      (ctl_start),
    .stop_req   (ctl_stop),
    .conv_done  (conv_done),
    .launch     (seq_launch),
    .done_ok    (seq_done_ok),
    .conv_start (conv_start),
    .busy       (seq_busy)
  );

  adc_result_regs #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .done_ok  (seq_done_ok),
    .code     (conv_code),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .stop_req (ctl_stop),
    .result   (res_value),
    .eoc      (res_eoc),
    .lock     (res_lock),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = {ctl_chan, ctl_start, ctl_mode};
      ADDR_STAT: bus_rdata[1:0]        = {seq_busy, res_eoc};
      ADDR_LO:   bus_rdata             = {res_value[LO_BITS-1:0], {(8-LO_BITS){1'b0}}};
      ADDR_HI:   bus_rdata             = res_value[RES_W-1:LO_BITS];
      default:   bus_rdata             = '0;
    endcase
  end

  assign conv_chan = ctl_chan;

endmodule

// File: rtl/adc_repeat_seq_chk.sv
module adc_repeat_seq_chk
  import adc_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       conv_done,
  input logic       conv_start,
  input logic       irq,
  input logic       busy,
  input logic       lock,
  input logic       eoc,
  input logic       stop_req
);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(conv_done));

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && lock) |=> !irq);

  // R5
  relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy && !conv_start && !stop_req) |=> conv_start);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!busy && !conv_start));

  // R6
  eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_HI) && !conv_done) |=> !eoc);

endmodule

bind adc_repeat_seq adc_repeat_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .irq        (irq),
  .busy       (seq_busy),
  .lock       (res_lock),
  .eoc        (res_eoc),
  .stop_req   (ctl_stop)
);

// File: tb/sim_adc_repeat_seq.sv
module sim_adc_repeat_seq;

  localparam int CLK_P = 10;
  localparam int LAT   = 12;
  localparam int RES_W = 10;
  localparam int CH_W  = 5;

  logic             clk;
  logic             rst_n;
  logic             bus_wr, bus_rd;
  logic [1:0]       bus_addr;
  logic [7:0]       bus_wdata;
  logic [7:0]       bus_rdata;
  logic             conv_start;
  logic [CH_W-1:0]  conv_chan;
  logic             conv_done;
  logic [RES_W-1:0] conv_code;
  logic             irq;

  int checks = 0;
  int errors = 0;

  adc_repeat_seq #(.RES_W(RES_W), .CH_W(CH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_code(conv_code), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // engine model: fixed latency, code computed from channel and sequence number
  int              eng_cnt = 0;
  logic [CH_W-1:0] eng_ch  = '0;
  int              eng_seq = 0;

  function automatic logic [RES_W-1:0] code_of(int ch, int n);
    return RES_W'((ch * 83 + n * 29 + 7) % 1024);
  endfunction

  always @(posedge clk) begin
    if (conv_start) begin
      eng_cnt <= LAT;
      eng_ch  <= conv_chan;
    end else if (eng_cnt != 0) begin
      eng_cnt <= eng_cnt - 1;
    end
    if (conv_done) eng_seq <= eng_seq + 1;
  end

  assign conv_done = (eng_cnt == 1);
  assign conv_code = code_of(int'(eng_ch), eng_seq);

  // port monitors
  int               cyc = 0, done_cnt = 0, start_cnt = 0, irq_cnt = 0;
  int               done_cyc = 0, start_cyc = 0;
  logic [RES_W-1:0] last_code = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (conv_done) begin
      done_cnt  <= done_cnt + 1;
      last_code <= conv_code;
      done_cyc  <= cyc;
    end
    if (conv_start) begin
      start_cnt <= start_cnt + 1;
      start_cyc <= cyc;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #(CLK_P/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!irq && t < 1000);
    chk(req, int'(irq), 1);
  endtask

  task automatic read_result(output logic [RES_W-1:0] v, output logic [5:0] lo_pad);
    logic [7:0] lo, hi;
    bus_read(2'd2, lo);
    bus_read(2'd3, hi);
    v      = {hi, lo[7:6]};
    lo_pad = lo[5:0];
  endtask

  logic [7:0]       rv;
  logic [RES_W-1:0] res, exp0, exp1;
  logic [5:0]       pad;
  int               s0, n0, d0;

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    bus_read(2'd0, rv); chk("R1 ctrl", int'(rv), 0);
    bus_read(2'd1, rv); chk("R1 status", int'(rv), 0);

    // R2 mode 01 with start launches nothing
    s0 = start_cnt;
    bus_write(2'd0, 8'b0000_0101);
    repeat (6) @(negedge clk);
    chk("R2 no launch in mode 01", start_cnt, s0);
    bus_read(2'd1, rv); chk("R10 busy stays 0", int'(rv[1]), 0);
    bus_write(2'd0, 8'h00);

    // sweep every channel, three repeat conversions each
    for (int ch = 0; ch < (1 << CH_W); ch++) begin
      s0 = start_cnt;
      bus_write(2'd0, {ch[CH_W-1:0], 1'b1, 2'b11});
      bus_read(2'd0, rv);
      chk("R3 ctrl readback, start cleared", int'(rv), int'({ch[CH_W-1:0], 1'b0, 2'b11}));
      chk("R2 one start pulse", start_cnt, s0 + 1);
      chk("R3 conv_chan", int'(conv_chan), ch);
      bus_read(2'd1, rv); chk("R10 busy after launch", int'(rv[1]), 1);
      for (int k = 0; k < 3; k++) begin
        wait_irq("R4 interrupt");
        exp0 = last_code;
        bus_read(2'd1, rv); chk("R4 eoc set", int'(rv[0]), 1);
        read_result(res, pad);
        chk("R4 stored code", int'(res), int'(exp0));
        chk("R11 low pad zero", int'(pad), 0);
        chk("R4 code matches channel", int'(exp0), int'(code_of(ch, eng_seq - 1)));
        bus_read(2'd1, rv); chk("R6 eoc cleared, R10 busy held", int'(rv[1:0]), 2);
        chk("R5 relaunch next cycle", start_cyc - done_cyc, 1);
      end
      bus_write(2'd0, {ch[CH_W-1:0], 3'b000});
      bus_read(2'd1, rv); chk("R9 busy cleared by stop", int'(rv[1]), 0);
    end

    // R7 completion while half read is dropped; R8 lock released by high read
    bus_write(2'd0, {5'd9, 1'b1, 2'b11});
    wait_irq("R4 interrupt");
    exp0 = last_code;
    bus_read(2'd2, rv);
    chk("R7 low byte", int'(rv[7:6]), int'(exp0[1:0]));
    n0 = irq_cnt; d0 = done_cnt;
    for (int t = 0; t < 1000 && done_cnt == d0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7 engine completed in window", int'(done_cnt > d0), 1);
    chk("R7 no interrupt while locked", irq_cnt, n0);
    bus_read(2'd3, rv);
    chk("R7 high byte kept", int'(rv), int'(exp0[RES_W-1:2]));
    wait_irq("R8 interrupt after unlock");
    exp1 = last_code;
    read_result(res, pad);
    chk("R8 new result stored", int'(res), int'(exp1));

    // R9 forced stop in the middle of a conversion
    wait_irq("R4 interrupt");
    exp1 = last_code;
    read_result(res, pad);
    chk("R4 result before stop", int'(res), int'(exp1));
    repeat (2) @(negedge clk);
    s0 = start_cnt; n0 = irq_cnt;
    bus_write(2'd0, 8'h00);
    repeat (LAT + 6) @(negedge clk);
    chk("R9 no start after stop", start_cnt, s0);
    chk("R9 no irq after stop", irq_cnt, n0);
    bus_read(2'd1, rv); chk("R9 status idle", int'(rv), 0);
    read_result(res, pad);
    chk("R9 result unchanged", int'(res), int'(exp1));
    bus_read(2'd0, rv); chk("R9 ctrl off", int'(rv[2:0]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule